// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Timers

This block keeps one free-running up-counter for a group of cores and gives every core its own compare register and timer interrupt line. Software on any core reads the count as two 32-bit words and programs a 64-bit compare value. When the count reaches or passes a core's compare value, that core's interrupt line goes high and stays high until software writes either word of that compare register. The write both sets the next deadline and acknowledges the interrupt.

Access goes through a simple single-cycle register bus with a 32-bit data path. Each access carries the index of the requesting core. A local compare window always targets the requester's own compare register. A per-core peer selector redirects a second window to any other core's compare register. The counter width is fixed at build time as 32 plus four times a width code, and that code is visible to software. After reset the counter is stopped. It starts when software clears the halt bit.

Top module: `shared_count_timer`

## Requirements
- R1: After reset the halt bit is 1, the count is 0, every timer interrupt is low, every compare register reads all ones within the counter width, and every peer selector is 0.
- R2: While the halt bit is 1 the count holds. When a control write clears it, the count rises by one on every clock after the clock of that write, wrapping modulo 2 to the power of the counter width.
- R3: Register index 1 returns count bits 31:0 and index 2 returns bits 63:32 of the live count. Bits at or above the counter width read as 0.
- R4: Register index 0 is the control word. Bit 0 is the read/write halt bit. Bits 7:4 return the read-only width code WIDTH_CODE, and the counter width is 32 + 4*WIDTH_CODE. All other bits read 0, and writes to the code bits have no effect.
- R5: Indices 3 (low word) and 4 (high word) read and write the compare register of the core named by bus_core.
- R6: A timer interrupt goes high on the clock after a cycle in which count >= that core's compare value. It then stays high until that core's compare register is written.
- R7: A write to either word of a compare register, including a write of the value it already holds, clears that core's interrupt at that clock. If count >= compare still holds afterwards, the interrupt returns one clock later.
- R8: Index 5 is the requesting core's peer selector, held in bits 1:0 for four cores. Indices 6 (low) and 7 (high) read and write the compare register of the core that the selector names.
- R9: A compare value already below the count when it is written asserts the interrupt exactly one clock after the clearing write.
- R10: Writes to indices 1 and 2 have no effect on the count. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_core | input | CORE_W | Index of the requesting core |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access (combinational) |
| timer_irq | output | NUM_CORES | Per-core timer interrupt level |

## Verification
The bench drives several kinds of compare deadline. The first is a deadline a few clocks ahead, which shows whether the interrupt fires on the right clock. The second rewrites the same value while the interrupt is pending, which checks that the acknowledge clears the line and that the line comes back because the condition still holds. The third is a deadline in the high word, which must keep the line low. The fourth is a value already passed, which must fire on the next clock. Peer-window writes are checked against both the selected core's interrupt and the requester's own register, which must stay unchanged, so a window that hits the wrong core shows up. Halt toggling and writes to the count words check, through repeated count reads, that the counter moves only while running.

// File: rtl/sct_pkg.sv
// Package: register indices and control-word field positions shared by
// the shared counter block and its checker.
package sct_pkg;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int CTRL_HALT_BIT = 0;
    localparam int CTRL_CODE_LSB = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL     = 3'd0,
        RA_CNT_LO   = 3'd1,
        RA_CNT_HI   = 3'd2,
        RA_OWN_LO   = 3'd3,
        RA_OWN_HI   = 3'd4,
        RA_PEER_SEL = 3'd5,
        RA_PEER_LO  = 3'd6,
        RA_PEER_HI  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/sct_counter.sv
// sct_counter: the shared up-counter and its halt bit.
// Assumes CNT_W is between 32 and 64. The halt bit resets to 1, so the
// counter sits at zero until software clears halt.
module sct_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             halt_in,
    output logic             halt_q,
    output logic [CNT_W-1:0] count_q
);
    // Halt bit: set at reset, loaded by control-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       halt_q <= 1'b1;
        else if (ctrl_we) halt_q <= halt_in;
    end

    // Counter: advances by one each clock while not halted, wraps at CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (!halt_q) count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/sct_cmp_unit.sv
// sct_cmp_unit: one core's compare register and its pending interrupt.
// Assumes 32 <= CNT_W <= 64. The compare value keeps only CNT_W bits, and
// the upper bits of the 64-bit view read as zero. Any write clears the
// pending level. The reached test (count >= compare) runs every clock.
module sct_cmp_unit #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic [CNT_W-1:0] count,
    output logic [63:0]      cmp_val,
    output logic             irq
);
    logic [CNT_W-1:0] cmp_q;
    logic [63:0]      cmp_nxt;

    // Widen the stored compare to the 64-bit software view.
    generate
        if (CNT_W == 64) begin : g_full
            assign cmp_val = cmp_q;
        end else begin : g_ext
            assign cmp_val = {{(64-CNT_W){1'b0}}, cmp_q};
        end
    endgenerate

    // Merge the written word into the current 64-bit view.
    always_comb begin
        cmp_nxt = cmp_val;
        if (wr_hi) cmp_nxt[63:32] = wr_data;
        else       cmp_nxt[31:0]  = wr_data;
    end

    // Compare register: all ones at reset, updated by word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp_q <= '1;
        else if (wr_en) cmp_q <= cmp_nxt[CNT_W-1:0];
    end

    // Pending level: cleared by any write, set when the count has reached compare.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (wr_en)            irq <= 1'b0;
        else if (count >= cmp_q)   irq <= 1'b1;
    end
endmodule

// File: rtl/sct_bus_decode.sv
// sct_bus_decode: turns one register-bus access into write strobes and
// read data, and holds each core's peer selector.
// Assumes one access per cycle. Accesses naming a core index at or above
// NUM_CORES, or a peer selector at or above NUM_CORES, write nothing and
// read zero.
module sct_bus_decode
    import sct_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int CORE_W     = 2,
    parameter int WIDTH_CODE = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_en,
    input  logic                              bus_we,
    input  logic [CORE_W-1:0]                 bus_core,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [CORE_W-1:0]                 sel_wdata,
    input  logic                              halt,
    input  logic [63:0]                       count64,
    input  logic [NUM_CORES-1:0][63:0]        cmp_vals,
    output logic                              ctrl_we,
    output logic [NUM_CORES-1:0]              cmp_we,
    output logic                              wr_hi,
    output logic [DATA_W-1:0]                 bus_rdata
);
    logic [NUM_CORES-1:0][CORE_W-1:0] sel_q;
    logic [CORE_W-1:0]                peer_idx;
    logic                             core_ok;
    logic                             peer_ok;
    logic                             own_win;
    logic                             peer_win;
    logic                             wr_acc;
    logic [63:0]                      own_val;
    logic [63:0]                      peer_val;
    reg_addr_e                        addr_e;

    assign addr_e   = reg_addr_e'(bus_addr);
    assign core_ok  = 32'(bus_core) < NUM_CORES;
    assign peer_idx = core_ok ? sel_q[bus_core] : '0;
    assign peer_ok  = core_ok && (32'(peer_idx) < NUM_CORES);
    assign own_win  = (addr_e == RA_OWN_LO)  || (addr_e == RA_OWN_HI);
    assign peer_win = (addr_e == RA_PEER_LO) || (addr_e == RA_PEER_HI);
    assign wr_hi    = (addr_e == RA_OWN_HI)  || (addr_e == RA_PEER_HI);
    assign wr_acc   = bus_en && bus_we && core_ok;
    assign ctrl_we  = wr_acc && (addr_e == RA_CTRL);
    assign own_val  = core_ok ? cmp_vals[bus_core] : 64'd0;
    assign peer_val = peer_ok ? cmp_vals[peer_idx] : 64'd0;

    // One write strobe per compare unit, reached locally or through the peer window.
    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_we
            assign cmp_we[g] = wr_acc &&
                ((own_win  && (bus_core == CORE_W'(g))) ||
                 (peer_win && peer_ok && (peer_idx == CORE_W'(g))));
        end
    endgenerate

    // Peer selectors: one per requesting core, zero at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_acc && (addr_e == RA_PEER_SEL)) begin
            sel_q[bus_core] <= sel_wdata;
        end
    end

    // Read mux: combinational data for the access presented this cycle.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we && core_ok) begin
            unique case (addr_e)
                RA_CTRL: begin
                    bus_rdata[CTRL_HALT_BIT]                  = halt;
                    bus_rdata[CTRL_CODE_LSB +: 4]             = 4'(WIDTH_CODE);
                end
                RA_CNT_LO:   bus_rdata = count64[31:0];
                RA_CNT_HI:   bus_rdata = count64[63:32];
                RA_OWN_LO:   bus_rdata = own_val[31:0];
                RA_OWN_HI:   bus_rdata = own_val[63:32];
                RA_PEER_SEL: bus_rdata = 32'(peer_idx);
                RA_PEER_LO:  bus_rdata = peer_val[31:0];
                RA_PEER_HI:  bus_rdata = peer_val[63:32];
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/shared_count_timer.sv
// shared_count_timer: top level. One shared counter, NUM_CORES compare
// units and the bus decoder.
// Assumes NUM_CORES >= 2 and WIDTH_CODE <= 8, so the counter is 32 to
// 64 bits wide.
module shared_count_timer
    import sct_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int WIDTH_CODE = 8,
    parameter int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [CORE_W-1:0]    bus_core,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] timer_irq
);
    localparam int CNT_W = 32 + 4 * WIDTH_CODE;

    logic                       halt_q;
    logic                       ctrl_we;
    logic                       wr_hi;
    logic [CNT_W-1:0]           count_q;
    logic [63:0]                count64;
    logic [NUM_CORES-1:0]       cmp_we;
    logic [NUM_CORES-1:0][63:0] cmp_vals;

    // Widen the count to the 64-bit software view.
    generate
        if (CNT_W == 64) begin : g_full
            assign count64 = count_q;
        end else begin : g_ext
            assign count64 = {{(64-CNT_W){1'b0}}, count_q};
        end
    endgenerate

    sct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .halt_in (bus_wdata[CTRL_HALT_BIT]),
        .halt_q  (halt_q),
        .count_q (count_q)
    );

    sct_bus_decode #(
        .NUM_CORES  (NUM_CORES),
        .CORE_W     (CORE_W),
        .WIDTH_CODE (WIDTH_CODE)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_core  (bus_core),
        .bus_addr  (bus_addr),
        .sel_wdata (bus_wdata[CORE_W-1:0]),
        .halt      (halt_q),
        .count64   (count64),
        .cmp_vals  (cmp_vals),
        .ctrl_we   (ctrl_we),
        .cmp_we    (cmp_we),
        .wr_hi     (wr_hi),
        .bus_rdata (bus_rdata)
    );

    // One compare unit per core.
    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
            sct_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cmp_we[g]),
                .wr_hi   (wr_hi),
                .wr_data (bus_wdata),
                .count   (count_q),
                .cmp_val (cmp_vals[g]),
                .irq     (timer_irq[g])
            );
        end
    endgenerate
endmodule

// File: rtl/sct_checker.sv
// sct_checker: temporal properties of shared_count_timer, bound to the top.
// Assumes it sees the halt bit, the raw count, the per-core compare write
// strobes and the interrupt outputs.
module sct_checker #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 halt,
    input logic [CNT_W-1:0]     count,
    input logic [NUM_CORES-1:0] cmp_we,
    input logic [NUM_CORES-1:0] timer_irq
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (count == $past(count)));                                   // R2
    AST_RUN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> (count == $past(count) + 1'b1));                           // R2
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_we));                                                   // R8

    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_irq
            AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                cmp_we[g] |=> !timer_irq[g]);                                // R7
            AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (timer_irq[g] && !cmp_we[g]) |=> timer_irq[g]);              // R6
        end
    endgenerate
endmodule

bind shared_count_timer sct_checker #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W)
) u_sct_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt_q),
    .count     (count_q),
    .cmp_we    (cmp_we),
    .timer_irq (timer_irq)
);

// File: tb/shared_count_timer_tb.sv
// Bench: a behavioural reference model advanced on every clock. Each cycle
// it compares the interrupt lines, and on every read it compares the read data.
`timescale 1ns/1ps
module shared_count_timer_tb;
    localparam int NC   = 4;
    localparam int CODE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_core = '0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] timer_irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // Reference state
    logic [63:0]   cnt_m  = 64'd0;
    logic          halt_m = 1'b1;
    logic [63:0]   cmp_m [NC];
    logic [1:0]    sel_m [NC];
    logic [NC-1:0] irq_m  = '0;

    always #10 clk = ~clk;

    shared_count_timer #(.NUM_CORES(NC), .WIDTH_CODE(CODE)) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_en (bus_en), .bus_we (bus_we),
        .bus_core (bus_core), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .timer_irq (timer_irq)
    );

    function automatic logic [31:0] model_read(int core, int addr);
        case (addr)
            0: return {24'd0, 4'(CODE), 3'd0, halt_m};
            1: return cnt_m[31:0];
            2: return cnt_m[63:32];
            3: return cmp_m[core][31:0];
            4: return cmp_m[core][63:32];
            5: return 32'(sel_m[core]);
            6: return cmp_m[sel_m[core]][31:0];
            default: return cmp_m[sel_m[core]][63:32];
        endcase
    endfunction

    task automatic model_update(bit en, bit we, int core, int addr, logic [31:0] wd);
        int tgt = -1;
        if (en && we && (addr == 3 || addr == 4)) tgt = core;
        if (en && we && (addr == 6 || addr == 7)) tgt = int'(sel_m[core]);
        for (int i = 0; i < NC; i++) begin
            if (i == tgt)               irq_m[i] = 1'b0;
            else if (cnt_m >= cmp_m[i]) irq_m[i] = 1'b1;
        end
        if (tgt >= 0) begin
            if (addr == 4 || addr == 7) cmp_m[tgt][63:32] = wd;
            else                        cmp_m[tgt][31:0]  = wd;
        end
        if (!halt_m) cnt_m = cnt_m + 64'd1;
        if (en && we && addr == 0) halt_m = wd[0];
        if (en && we && addr == 5) sel_m[core] = wd[1:0];
    endtask

    // One bus cycle: drive, check, then advance the model at the edge.
    task automatic step(bit en, bit we, int core, int addr, logic [31:0] wd, string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_en = en; bus_we = we; bus_core = 2'(core);
        bus_addr = 3'(addr); bus_wdata = wd;
        #5;
        vectors++;
        if (timer_irq !== irq_m) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", req, timer_irq, irq_m);
        end
        if (en && !we) begin
            exp = model_read(core, addr);
            vectors++;
            if (bus_rdata !== exp) begin
                fails++;
                $display("FAIL %s read core=%0d idx=%0d actual=%h expected=%h",
                         req, core, addr, bus_rdata, exp);
            end
        end
        @(posedge clk);
        model_update(en, we, core, addr, wd);
    endtask

    task automatic rd(int core, int addr, string req);
        step(1'b1, 1'b0, core, addr, 32'd0, req);
    endtask

    task automatic wr(int core, int addr, logic [31:0] wd, string req);
        step(1'b1, 1'b1, core, addr, wd, req);
    endtask

    task automatic poll(int n, string req);
        for (int k = 0; k < n; k++) rd(k % NC, 1, req);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            cmp_m[i] = '1;
            sel_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(0, 0, "R1"); rd(1, 1, "R1"); rd(2, 2, "R1");
        rd(3, 3, "R1"); rd(3, 4, "R1"); rd(2, 5, "R1");
        poll(4, "R2 halted");

        // R4: code bits are read-only, halt stays set
        wr(1, 0, 32'hFFFF_FFF1, "R4");
        rd(1, 0, "R4");
        poll(3, "R2 halted");
        wr(0, 0, 32'h0000_0000, "R2 start");
        poll(6, "R2 running");
        rd(2, 2, "R3");

        // R10: count words ignore writes
        wr(3, 1, 32'h0000_1234, "R10");
        wr(3, 2, 32'h0000_0055, "R10");
        rd(3, 1, "R10"); rd(3, 2, "R10");

        // R5/R6: core 1 deadline a few clocks ahead
        wr(1, 4, 32'd0, "R5");
        wr(1, 3, cnt_m[31:0] + 32'd12, "R5");
        rd(1, 3, "R5"); rd(0, 3, "R5");
        poll(16, "R6");

        // R7: rewrite same value while pending, then a far deadline
        wr(1, 3, cmp_m[1][31:0], "R7");
        poll(3, "R7");
        wr(1, 4, 32'd1, "R7");
        poll(4, "R7");

        // R8: core 0 programs core 2 through the peer window
        wr(0, 5, 32'd2, "R8");
        rd(0, 5, "R8");
        wr(0, 7, 32'd0, "R8");
        wr(0, 6, cnt_m[31:0] + 32'd4, "R8");
        rd(0, 6, "R8"); rd(2, 3, "R8"); rd(0, 3, "R8"); rd(0, 4, "R8");
        poll(8, "R8");
        wr(3, 5, 32'd2, "R8");
        wr(3, 7, 32'hFFFF_FFFF, "R8");
        rd(2, 4, "R8");
        poll(3, "R8");

        // R9: a deadline already passed fires one clock later
        wr(3, 4, 32'd0, "R9");
        poll(2, "R9");
        wr(3, 3, 32'd5, "R9");
        poll(4, "R9");

        // R2: halt again and confirm the count freezes
        wr(2, 0, 32'd1, "R2 stop");
        poll(5, "R2 halted");
        rd(0, 0, "R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule